// File: doc/BRIEF.md
# Strided Vector Memory Mover

This block transfers one whole vector between a vector register file and a memory split into word-interleaved banks. A command gives the direction (load or store), a base word address and a vector register number. At acceptance the block also samples the element count and the element spacing from two configuration inputs. Element i lives at word address base + i·stride. The bank that serves it is selected by the low address bits.

Every bank answers a request a fixed number of cycles later and can hold only one access at a time. The block issues at most one element request per cycle, in element order. It holds the stream back while the target bank is still occupied. Because the latency is fixed and issue is in order, responses come back in element order. Loaded words are written into the destination register at a running element index. Stored words are read from the source register as each request leaves. A one-cycle completion pulse closes each command.

Top module: `vec_ldst_unit`

## Requirements
- R1: After reset, cmd_ready is 1 and mem_req, vrf_we and done are 0.
- R2: A command is taken on a cycle where cmd_valid and cmd_ready are both 1. That cycle latches the direction, base, register, vlen and vstride. cmd_ready then stays 0 until the completion pulse, and commands offered meanwhile have no effect.
- R3: Element i is requested at word address (base + i·vstride) mod 2^AW, where vstride is two's complement. Requests go out in increasing i. mem_bank equals the low log2(NBANK) bits of that address.
- R4: The first request is made in the cycle after acceptance. While the target bank is free, a new request follows every cycle. With NBANK ≥ LAT and unit stride, the stream never pauses.
- R5: A request to a bank is made no sooner than LAT cycles after the previous request to the same bank. Until then the whole stream waits and later elements are not reordered.
- R6: The memory presents mem_rsp, with mem_rdata on a load, exactly LAT cycles after the request. On a load, each response is written in the same cycle to the command's register (vrf_we=1) at element index 0, 1, 2 … in order.
- R7: On a store, mem_we is 1 and mem_wdata carries element i of the source register, read through vrf_rd_reg/vrf_rd_idx during the request. vrf_we stays 0.
- R8: A vlen above MAXVL is treated as MAXVL.
- R9: A vlen of 0 makes no memory request. It raises done in the cycle after acceptance, and cmd_ready stays 1.
- R10: done is a one-cycle pulse in the cycle after the last response of the command. cmd_ready returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | AW | Word address of element 0 |
| cmd_vreg | input | log2(NVREG) | Vector register number |
| vlen | input | log2(MAXVL+1) | Element count |
| vstride | input | AW | Element spacing in words, two's complement |
| mem_req | output | 1 | Element request |
| mem_we | output | 1 | Request is a write |
| mem_bank | output | log2(NBANK) | Target bank |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Store data |
| mem_rsp | input | 1 | Response, LAT cycles after its request |
| mem_rdata | input | DW | Load data |
| vrf_rd_reg | output | log2(NVREG) | Register-file read register |
| vrf_rd_idx | output | log2(MAXVL) | Register-file read element |
| vrf_rdata | input | DW | Register-file read data (combinational) |
| vrf_we | output | 1 | Register-file write enable |
| vrf_wr_reg | output | log2(NVREG) | Register-file write register |
| vrf_wr_idx | output | log2(MAXVL) | Register-file write element |
| vrf_wdata | output | DW | Register-file write data |
| done | output | 1 | Completion pulse |

## Verification
The bench uses the defaults: 16 banks, an 11-cycle latency, 16-bit word addresses, 32-bit data, 4 registers of 64 elements. With 16 banks against 11 cycles, unit stride must run with no gaps. Strides of 16 and 8 keep returning to one or two banks, which forces stalls whose exact lengths the bench predicts. A negative stride wraps below address zero, and a length of 70 reaches the 64-element clamp.

// File: rtl/vec_ldst_unit.sv
module vec_ldst_unit #(
  parameter int NBANK = 16,
  parameter int LAT   = 11,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NVREG = 4,
  parameter int MAXVL = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_store,
  input  logic [AW-1:0]              cmd_base,
  input  logic [$clog2(NVREG)-1:0]   cmd_vreg,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  input  logic [AW-1:0]              vstride,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [$clog2(NBANK)-1:0]   mem_bank,
  output logic [AW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_wdata,
  input  logic                       mem_rsp,
  input  logic [DW-1:0]              mem_rdata,
  output logic [$clog2(NVREG)-1:0]   vrf_rd_reg,
  output logic [$clog2(MAXVL)-1:0]   vrf_rd_idx,
  input  logic [DW-1:0]              vrf_rdata,
  output logic                       vrf_we,
  output logic [$clog2(NVREG)-1:0]   vrf_wr_reg,
  output logic [$clog2(MAXVL)-1:0]   vrf_wr_idx,
  output logic [DW-1:0]              vrf_wdata,
  output logic                       done
);
  localparam int BW = $clog2(NBANK);
  localparam int RW = $clog2(NVREG);
  localparam int IW = $clog2(MAXVL);
  localparam int LW = $clog2(MAXVL+1);
  localparam int CW = $clog2(LAT);

  logic          busy, st, done_q;
  logic [RW-1:0] vreg;
  logic [LW-1:0] vl, iss_n, rsp_n;
  logic [AW-1:0] addr, stride;
  logic [CW-1:0] bcnt [NBANK];
  logic [BW-1:0] bank;
  logic [LW-1:0] vl_clamp;

  assign bank      = addr[BW-1:0];
  assign vl_clamp  = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
  assign cmd_ready = !busy;
  assign mem_req   = busy && (iss_n < vl) && (bcnt[bank] == '0);
  assign mem_we    = st;
  assign mem_bank  = bank;
  assign mem_addr  = addr;
  assign mem_wdata = vrf_rdata;
  assign vrf_rd_reg = vreg;
  assign vrf_rd_idx = iss_n[IW-1:0];
  assign vrf_we     = busy && !st && mem_rsp;
  assign vrf_wr_reg = vreg;
  assign vrf_wr_idx = rsp_n[IW-1:0];
  assign vrf_wdata  = mem_rdata;
  assign done       = done_q;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                           bcnt[g] <= '0;
      else if (mem_req && bank == BW'(g))   bcnt[g] <= CW'(LAT-1);
      else if (bcnt[g] != '0)               bcnt[g] <= bcnt[g] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      st     <= 1'b0;
      done_q <= 1'b0;
      vreg   <= '0;
      vl     <= '0;
      iss_n  <= '0;
      rsp_n  <= '0;
      addr   <= '0;
      stride <= '0;
    end else begin
      done_q <= 1'b0;
      if (cmd_valid && !busy) begin
        st     <= cmd_store;
        vreg   <= cmd_vreg;
        vl     <= vl_clamp;
        stride <= vstride;
        addr   <= cmd_base;
        iss_n  <= '0;
        rsp_n  <= '0;
        if (vl_clamp == '0) done_q <= 1'b1;
        else                busy   <= 1'b1;
      end
      if (mem_req) begin
        addr  <= addr + stride;
        iss_n <= iss_n + 1'b1;
      end
      if (busy && mem_rsp) begin
        rsp_n <= rsp_n + 1'b1;
        if (rsp_n == vl - LW'(1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vec_ldst_chk.sv
module vec_ldst_chk #(
  parameter int NBANK = 16,
  parameter int LAT   = 11,
  parameter int MAXVL = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic                     cmd_store,
  input logic                     mem_req,
  input logic [$clog2(NBANK)-1:0] mem_bank,
  input logic                     mem_rsp,
  input logic                     vrf_we,
  input logic [$clog2(MAXVL)-1:0] vrf_wr_idx,
  input logic                     done
);
  localparam int BW  = $clog2(NBANK);
  localparam int AGW = $clog2(LAT+1);
  localparam int IW  = $clog2(MAXVL);

  logic [AGW-1:0] age [NBANK];
  logic [IW-1:0]  wcnt;
  logic           st_l;

  for (genvar g = 0; g < NBANK; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                               age[g] <= AGW'(LAT);
      else if (mem_req && mem_bank == BW'(g))   age[g] <= AGW'(1);
      else if (age[g] != AGW'(LAT))             age[g] <= age[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      st_l <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      wcnt <= '0;
      st_l <= cmd_store;
    end else if (vrf_we) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  assert_bank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> age[mem_bank] >= AGW'(LAT));
  assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req && !mem_rsp);
  assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> vrf_wr_idx == wcnt);
  assert_store_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> !st_l);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind vec_ldst_unit vec_ldst_chk #(.NBANK(NBANK), .LAT(LAT), .MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_store(cmd_store), .mem_req(mem_req), .mem_bank(mem_bank),
  .mem_rsp(mem_rsp), .vrf_we(vrf_we), .vrf_wr_idx(vrf_wr_idx), .done(done)
);

// File: tb/tb_vec_ldst_unit.sv
`timescale 1ns/1ps
module tb_vec_ldst_unit;
  localparam int NBANK = 16, LAT = 11, AW = 16, DW = 32, NVREG = 4, MAXVL = 64;
  localparam int RW = $clog2(NVREG), IW = $clog2(MAXVL), LW = $clog2(MAXVL+1);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_store = 0;
  logic [AW-1:0] cmd_base = 0, vstride = 0;
  logic [RW-1:0] cmd_vreg = 0;
  logic [LW-1:0] vlen = 0;
  logic mem_req, mem_we, mem_rsp = 0;
  logic [$clog2(NBANK)-1:0] mem_bank;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = 0, vrf_rdata, vrf_wdata;
  logic [RW-1:0] vrf_rd_reg, vrf_wr_reg;
  logic [IW-1:0] vrf_rd_idx, vrf_wr_idx;
  logic vrf_we, done;

  vec_ldst_unit #(.NBANK(NBANK), .LAT(LAT), .AW(AW), .DW(DW), .NVREG(NVREG), .MAXVL(MAXVL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_base(cmd_base), .cmd_vreg(cmd_vreg), .vlen(vlen),
    .vstride(vstride), .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .vrf_rd_reg(vrf_rd_reg), .vrf_rd_idx(vrf_rd_idx), .vrf_rdata(vrf_rdata),
    .vrf_we(vrf_we), .vrf_wr_reg(vrf_wr_reg), .vrf_wr_idx(vrf_wr_idx),
    .vrf_wdata(vrf_wdata), .done(done));

  int n_chk = 0, n_fail = 0;
  function automatic void chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  logic [DW-1:0] bvrf [NVREG][MAXVL];
  logic [DW-1:0] bmem [int];
  function automatic logic [DW-1:0] rd(int a);
    if (bmem.exists(a)) return bmem[a];
    return DW'(a) * 32'h9E3779B1 ^ 32'h0000C3A5;
  endfunction
  assign vrf_rdata = bvrf[vrf_rd_reg][vrf_rd_idx];

  int cyc = 0, en = 0, ni = 0, wi = 0, exp_done = -1, ereg = 0;
  bit est = 0, done_seen = 0;
  int exp_t [MAXVL], exp_a [MAXVL], bfree [NBANK];
  int rq_due [$];
  logic [DW-1:0] rq_dat [$];

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req) begin
        if (ni >= en) chk(0, "R3", "extra request", ni, en);
        else begin
          chk(cyc == exp_t[ni], "R4/R5", "request cycle", cyc, exp_t[ni]);
          chk(int'(mem_addr) == exp_a[ni], "R3", "address", mem_addr, exp_a[ni]);
          chk(int'(mem_bank) == exp_a[ni] % NBANK, "R3", "bank", mem_bank, exp_a[ni] % NBANK);
          chk(mem_we == est, "R7", "write flag", mem_we, est);
          if (est) begin
            chk(mem_wdata == bvrf[ereg][ni], "R7", "store data", mem_wdata, bvrf[ereg][ni]);
            bmem[exp_a[ni]] = mem_wdata;
            rq_dat.push_back('0);
          end else rq_dat.push_back(rd(exp_a[ni]));
          rq_due.push_back(cyc + LAT);
          ni++;
        end
      end else if (ni < en && cyc == exp_t[ni]) chk(0, "R4/R5", "missing request", cyc, exp_t[ni]);

      if (mem_rsp) begin
        logic [DW-1:0] d;
        d = rq_dat.pop_front();
        void'(rq_due.pop_front());
        chk(vrf_we == !est, "R6/R7", "write enable on response", vrf_we, !est);
        if (vrf_we) begin
          chk(int'(vrf_wr_idx) == wi, "R6", "write index", vrf_wr_idx, wi);
          chk(int'(vrf_wr_reg) == ereg, "R6", "write register", vrf_wr_reg, ereg);
          chk(vrf_wdata == d, "R6", "load data", vrf_wdata, d);
          bvrf[vrf_wr_reg][vrf_wr_idx] = vrf_wdata;
        end
        wi++;
      end else if (vrf_we) chk(0, "R6", "write without response", 1, 0);

      if (done) begin
        chk(cyc == exp_done, (en == 0) ? "R9" : "R10", "done cycle", cyc, exp_done);
        chk(cmd_ready, "R10", "ready with done", cmd_ready, 1);
        chk(ni == en && wi == en, "R8", "element count", ni, en);
        done_seen = 1;
      end else if (cyc == exp_done) chk(0, "R10", "missing done", 0, 1);

      if (cmd_valid && cmd_ready) begin
        int t;
        est = cmd_store; ereg = cmd_vreg;
        en = (int'(vlen) > MAXVL) ? MAXVL : int'(vlen);
        ni = 0; wi = 0; t = cyc + 1;
        for (int i = 0; i < en; i++) begin
          int a, b;
          a = (int'(cmd_base) + i * int'($signed(vstride))) & ((1 << AW) - 1);
          b = a % NBANK;
          if (t < bfree[b]) t = bfree[b];
          exp_t[i] = t; exp_a[i] = a; bfree[b] = t + LAT; t++;
        end
        exp_done = (en == 0) ? cyc + 1 : exp_t[en-1] + LAT + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rq_due.size() > 0 && rq_due[0] == cyc + 1) begin
      mem_rsp <= 1; mem_rdata <= rq_dat[0];
    end else begin
      mem_rsp <= 0; mem_rdata <= '0;
    end
  end

  task automatic run(bit s, int base, int r, int n, int stride, bit poke = 0);
    done_seen = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_store = s; cmd_base = AW'(base); cmd_vreg = RW'(r);
    vlen = LW'(n); vstride = AW'(stride);
    @(negedge clk);
    if (poke) begin
      cmd_store = !s; cmd_base = 16'h1234; vstride = 16'd7; vlen = LW'(3);
      repeat (4) @(negedge clk);
      chk(!cmd_ready || done_seen, "R2", "ready while busy", cmd_ready, 0);
    end
    cmd_valid = 0;
    while (!done_seen) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < NVREG; r++)
      for (int i = 0; i < MAXVL; i++) bvrf[r][i] = DW'((r << 16) | (i * 3 + 1));
    repeat (3) @(negedge clk);
    chk(cmd_ready && !mem_req && !vrf_we && !done, "R1", "reset outputs",
        {cmd_ready, mem_req, vrf_we, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !mem_req && !done, "R1", "idle after reset", cmd_ready, 1);
    run(0, 100, 1, 50, 1);
    run(1, 4000, 1, 20, 3);
    run(0, 4000, 2, 20, 3);
    run(0, 32, 3, 5, 16);
    run(0, 7, 2, 6, 8);
    run(0, 5, 0, 10, -1);
    run(1, 900, 0, 0, 1);
    chk(cmd_ready, "R9", "ready after empty command", cmd_ready, 1);
    run(0, 300, 0, 70, 1);
    run(1, 50000, 3, 12, 5, 1);
    run(1, 60000, 0, 64, 1);
    run(0, 60000, 1, 64, 1);
    for (int i = 0; i < 64; i++)
      chk(bvrf[1][i] == bvrf[0][i], "R7", "store then load round trip", bvrf[1][i], bvrf[0][i]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual no completion expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule